// File: doc/BRIEF.md
# Machine Clock Source Selection Controller

This block decides which of three sources drives the machine clock: the main oscillator clock, a multiplied PLL clock, or a slow sub-clock. Software sets two request levels and two 2-bit codes. One code sets the PLL multiplication factor and the other sets the oscillator stabilization wait. The controller does not switch the clock as soon as a request changes. It runs a switch sequence, drives a source-select code and a multiply factor to the clock multiplexer and the PLL, and raises two status bits only after the new source is in use. Software polls the status bits, not its own request bits, to learn that a switch has finished.

The stabilization and lock waits are counted on a reference tick input, not on the fast clock. While a switch is in progress the controller holds every new request. When the switch completes, a request that still differs from the active source starts a new switch. A low-power request is acknowledged only when no switch is running or being started.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset, `src_sel` is 0 (main clock), `pll_active` and `sub_active` are 0, `switching` is 0 and `mult_factor` is 1.
- R2: The requested source is decoded as follows. `fast_req`=0 requests the sub-clock whatever `pll_req` is. `fast_req`=1 with `pll_req`=0 requests the main clock. `fast_req`=1 with `pll_req`=1 requests the PLL clock. `src_sel` encodes main as 0, PLL as 1 and sub as 2. If the idle controller's requested source equals the active source, no switch starts.
- R3: A switch to the sub-clock from the main or the PLL clock keeps `switching` high for exactly one cycle. It then shows `src_sel`=2 with `sub_active`=1.
- R4: A switch from the PLL clock to the main clock keeps `switching` high for exactly one cycle. It then shows `src_sel`=0 with both status bits at 0.
- R5: A switch out of the sub-clock, to the main or the PLL clock, completes on the clock edge that samples the 2^Ek-th reference tick after acceptance. Ek is the exponent chosen by the `stab_code` k latched when the switch is accepted. Cycles without a tick do not count.
- R6: A switch from the main clock to the PLL clock waits 2^LOCK_EXP reference ticks for PLL lock. `src_sel` stays 0 during the wait and then becomes 1 with `pll_active`=1.
- R7: `mult_factor` equals `mult_code`+1, latched only when a switch to the PLL clock is accepted. If `mult_code` changes while the PLL clock is active and still requested, a relock starts. From the acceptance edge `src_sel` and the status show the main clock. After the lock wait they show the PLL clock with the new factor. A change of `mult_code` at any other time leaves `mult_factor` unchanged.
- R8: `switching` goes high on the edge that accepts a switch and goes low on the edge where the status bits take the new source. `src_sel` changes only on those two edges.
- R9: Request and code changes made while `switching` is high do not alter the switch in progress. After it completes, a request that still differs from the active source is accepted on the next edge.
- R10: `sleep_ack` equals `sleep_req` only while no switch is running and none is being accepted in the current cycle. Otherwise it is 0.
- R11: `pll_active` is 1 exactly when `src_sel` is 1, and `sub_active` is 1 exactly when `src_sel` is 2. The two status bits are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick used to count the stabilization and lock waits |
| fast_req | input | 1 | 0 requests the sub-clock, 1 requests a fast source |
| pll_req | input | 1 | With `fast_req`=1, chooses the PLL clock (1) or the main clock (0) |
| mult_code | input | 2 | PLL multiply code; the factor is the code plus one |
| stab_code | input | 2 | Oscillator stabilization wait selector |
| sleep_req | input | 1 | Low-power mode request |
| src_sel | output | 2 | Source select to the clock multiplexer: 0 main, 1 PLL, 2 sub |
| mult_factor | output | 3 | Multiply factor to the PLL, from 1 to 4 |
| pll_active | output | 1 | Status: the PLL clock is the machine clock |
| sub_active | output | 1 | Status: the sub-clock is the machine clock |
| switching | output | 1 | A clock switch is in progress |
| sleep_ack | output | 1 | The low-power request may take effect |

## Verification
Two events can fall in the same cycle: the end of a wait and a new request. The bench changes the request and the wait code partway through a long stabilization wait. It then checks that the first switch still ends after its own latched tick count on the originally requested source, and that the held request is accepted on the very next edge. The other coincidence is a low-power request in the cycle a switch is accepted. The bench raises `sleep_req` at the same moment as a request change and requires `sleep_ack` to stay low. The same low-power request given in an idle cycle must be acknowledged.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_HANDOFF = 2'd1,
        PH_OSC     = 2'd2,
        PH_LOCK    = 2'd3
    } sw_phase_e;

    // Software request levels; fast = 0 asks for the sub-clock.
    typedef struct packed {
        logic fast;
        logic pll;
    } clk_req_t;

    function automatic clk_src_e decode_req(clk_req_t r);
        if (!r.fast)
            return SRC_SUB;
        return r.pll ? SRC_PLL : SRC_MAIN;
    endfunction

    // Phase entered when a switch from 'from' to 'to' is accepted.
    function automatic sw_phase_e first_phase(clk_src_e from, clk_src_e to);
        if (to == SRC_SUB)
            return PH_HANDOFF;
        if (from == SRC_SUB)
            return PH_OSC;
        if (to == SRC_MAIN)
            return PH_HANDOFF;
        return PH_LOCK;
    endfunction

    function automatic logic [2:0] factor_of(logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

    function automatic int unsigned imax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clksel_req_decode.sv
`timescale 1ns/1ps
module clksel_req_decode
    import clksel_pkg::*;
(
    input  logic     fast_req,
    input  logic     pll_req,
    output clk_src_e want
);
    clk_req_t req;

    always_comb begin
        req.fast = fast_req;
        req.pll  = pll_req;
        want     = decode_req(req);
    end
endmodule

// File: rtl/clksel_stab_timer.sv
`timescale 1ns/1ps
module clksel_stab_timer #(
    parameter int unsigned E0  = 10,
    parameter int unsigned E1  = 13,
    parameter int unsigned E2  = 15,
    parameter int unsigned E3  = 17,
    parameter int unsigned ELK = 9,
    parameter int unsigned CW  = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic       use_lock,
    input  logic [1:0] wsel,
    output logic       done
);
    localparam int unsigned EXPS [4] = '{E0, E1, E2, E3};
    localparam logic [CW-1:0] LOCK_M1 = CW'((64'd1 << ELK) - 64'd1);

    logic [CW-1:0] tab [4];
    logic [CW-1:0] limit_m1;
    logic [CW-1:0] cnt;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign tab[g] = CW'((64'd1 << EXPS[g]) - 64'd1);
    end

    always_comb begin
        limit_m1 = use_lock ? LOCK_M1 : tab[wsel];
        done     = run && tick && (cnt == limit_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clksel_seq.sv
`timescale 1ns/1ps
module clksel_seq
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  clk_src_e   want,
    input  logic [1:0] mult_code,
    input  logic [1:0] stab_code,
    input  logic       timer_done,
    output clk_src_e   active,
    output sw_phase_e  phase,
    output logic [1:0] mult_q,
    output logic [1:0] stab_q,
    output logic       accept
);
    clk_src_e goal;
    logic     relock_need;

    always_comb begin
        relock_need = (active == SRC_PLL) && (want == SRC_PLL) && (mult_code != mult_q);
        accept      = (phase == PH_IDLE) && ((want != active) || relock_need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            active <= SRC_MAIN;
            goal   <= SRC_MAIN;
            mult_q <= 2'd0;
            stab_q <= 2'd0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        goal   <= want;
                        stab_q <= stab_code;
                        phase  <= first_phase(active, want);
                        if (want == SRC_PLL)
                            mult_q <= mult_code;
                        // relock: run on the main clock while the PLL settles
                        if (want == SRC_PLL && active == SRC_PLL)
                            active <= SRC_MAIN;
                    end
                end
                PH_HANDOFF: begin
                    active <= goal;
                    phase  <= PH_IDLE;
                end
                PH_OSC, PH_LOCK: begin
                    if (timer_done) begin
                        active <= goal;
                        phase  <= PH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int unsigned STAB_EXP0 = 10,
    parameter int unsigned STAB_EXP1 = 13,
    parameter int unsigned STAB_EXP2 = 15,
    parameter int unsigned STAB_EXP3 = 17,
    parameter int unsigned LOCK_EXP  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       fast_req,
    input  logic       pll_req,
    input  logic [1:0] mult_code,
    input  logic [1:0] stab_code,
    input  logic       sleep_req,
    output logic [1:0] src_sel,
    output logic [2:0] mult_factor,
    output logic       pll_active,
    output logic       sub_active,
    output logic       switching,
    output logic       sleep_ack
);
    localparam int unsigned MAXE = imax(imax(imax(STAB_EXP0, STAB_EXP1),
                                             imax(STAB_EXP2, STAB_EXP3)), LOCK_EXP);
    localparam int unsigned CW = (MAXE < 1) ? 1 : MAXE;

    clk_src_e  want;
    clk_src_e  active;
    sw_phase_e phase;
    logic [1:0] mult_q;
    logic [1:0] stab_q;
    logic       accept;
    logic       timer_done;
    logic       timer_run;
    logic       timer_lock;

    clksel_req_decode u_dec (
        .fast_req (fast_req),
        .pll_req  (pll_req),
        .want     (want)
    );

    clksel_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .want       (want),
        .mult_code  (mult_code),
        .stab_code  (stab_code),
        .timer_done (timer_done),
        .active     (active),
        .phase      (phase),
        .mult_q     (mult_q),
        .stab_q     (stab_q),
        .accept     (accept)
    );

    always_comb begin
        timer_run  = (phase == PH_OSC) || (phase == PH_LOCK);
        timer_lock = (phase == PH_LOCK);
    end

    clksel_stab_timer #(
        .E0  (STAB_EXP0),
        .E1  (STAB_EXP1),
        .E2  (STAB_EXP2),
        .E3  (STAB_EXP3),
        .ELK (LOCK_EXP),
        .CW  (CW)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .restart  (accept),
        .run      (timer_run),
        .tick     (tick),
        .use_lock (timer_lock),
        .wsel     (stab_q),
        .done     (timer_done)
    );

    always_comb begin
        src_sel     = active;
        mult_factor = factor_of(mult_q);
        pll_active  = (active == SRC_PLL);
        sub_active  = (active == SRC_SUB);
        switching   = (phase != PH_IDLE);
        sleep_ack   = sleep_req && (phase == PH_IDLE) && !accept;
    end
endmodule

// File: rtl/clksel_ctrl_chk.sv
`timescale 1ns/1ps
module clksel_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       fast_req,
    input logic [1:0] src_sel,
    input logic [2:0] mult_factor,
    input logic       pll_active,
    input logic       sub_active,
    input logic       switching,
    input logic       sleep_ack
);
    a_r11_status_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pll_active && sub_active));

    a_r11_status_matches_sel: assert property (@(posedge clk) disable iff (rst)
        (pll_active == (src_sel == 2'd1)) && (sub_active == (src_sel == 2'd2)));

    a_r8_sel_moves_only_at_edges: assert property (@(posedge clk) disable iff (rst)
        (!$rose(switching) && !$fell(switching)) |-> $stable(src_sel));

    a_r7_factor_only_on_accept: assert property (@(posedge clk) disable iff (rst)
        !$rose(switching) |-> $stable(mult_factor));

    a_r10_no_sleep_while_switching: assert property (@(posedge clk) disable iff (rst)
        switching |-> !sleep_ack);

    a_r2_sub_request_starts_switch: assert property (@(posedge clk) disable iff (rst)
        (!switching && !fast_req && src_sel != 2'd2) |=> switching);
endmodule

bind clksel_ctrl clksel_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fast_req    (fast_req),
    .src_sel     (src_sel),
    .mult_factor (mult_factor),
    .pll_active  (pll_active),
    .sub_active  (sub_active),
    .switching   (switching),
    .sleep_ack   (sleep_ack)
);

// File: tb/clksel_ctrl_test.sv
`timescale 1ns/1ps
module clksel_ctrl_test;
    localparam int E0 = 1, E1 = 2, E2 = 3, E3 = 4, ELK = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       fast_req = 1'b1;
    logic       pll_req = 1'b0;
    logic [1:0] mult_code = 2'd0;
    logic [1:0] stab_code = 2'd0;
    logic       sleep_req = 1'b0;
    logic [1:0] src_sel;
    logic [2:0] mult_factor;
    logic       pll_active, sub_active, switching, sleep_ack;

    int errors = 0, checks = 0;
    int tick_mode = 0;
    logic tick_ph = 1'b0;
    logic b_seen;
    int tk, bc;
    logic [1:0] first_src;
    bit finished = 0;

    clksel_ctrl #(
        .STAB_EXP0(E0), .STAB_EXP1(E1), .STAB_EXP2(E2), .STAB_EXP3(E3), .LOCK_EXP(ELK)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .fast_req(fast_req), .pll_req(pll_req),
        .mult_code(mult_code), .stab_code(stab_code), .sleep_req(sleep_req),
        .src_sel(src_sel), .mult_factor(mult_factor), .pll_active(pll_active),
        .sub_active(sub_active), .switching(switching), .sleep_ack(sleep_ack)
    );

    always #10 clk = ~clk;

    function automatic int stab_len(int code);
        int e;
        e = (code == 0) ? E0 : (code == 1) ? E1 : (code == 2) ? E2 : E3;
        return 1 << e;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_src(string req, int expv);
        chk(src_sel == 2'(expv), req, src_sel, expv);
        chk(pll_active == (expv == 1) && sub_active == (expv == 2), req,
            {pll_active, sub_active}, {expv == 1, expv == 2});
    endtask

    // one cycle: sample busy, drive the next tick, count ticks seen while busy
    task automatic cyc();
        @(negedge clk);
        b_seen  = switching;
        tick_ph = ~tick_ph;
        tick    = (tick_mode == 0) ? 1'b1 : tick_ph;
        if (b_seen) begin
            bc++;
            if (tick) tk++;
        end
    endtask

    // inputs were just set; follow the switch to its end
    task automatic run_switch();
        tk = 0; bc = 0;
        cyc();
        first_src = src_sel;
        for (int g = 0; g < 2000 && b_seen; g++) cyc();
    endtask

    task automatic req(logic f, logic p);
        fast_req = f;
        pll_req  = p;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk_src("R1 src", 0);
        chk(switching == 1'b0, "R1 busy", switching, 0);
        chk(mult_factor == 3'd1, "R1 factor", mult_factor, 1);

        // R2 no switch when request equals active source
        req(1, 0);
        repeat (3) cyc();
        chk(b_seen == 1'b0, "R2 equal request idle", b_seen, 0);

        // R2 both low selects sub; R3 one-cycle handoff
        req(0, 0);
        run_switch();
        chk(bc == 1, "R3 handoff length", bc, 1);
        chk_src("R2 both low gives sub", 2);

        for (int m = 0; m < 2; m++) begin
            tick_mode = m;
            for (int wc = 0; wc < 4; wc++) begin
                // be in sub
                req(0, wc[0]);
                if (src_sel != 2'd2) begin
                    run_switch();
                    chk(bc == 1, "R3 handoff length", bc, 1);
                end
                chk_src("R3 sub reached", 2);
                // leave sub to PLL (odd) or main (even)
                stab_code = 2'(wc);
                mult_code = 2'(3 - wc);
                req(1, wc[0]);
                run_switch();
                chk(tk == stab_len(wc), "R5 stab ticks", tk, stab_len(wc));
                chk(first_src == 2'd2, "R5 sub during wait", first_src, 2);
                chk_src("R5 target", wc[0] ? 1 : 0);
                if (wc[0]) begin
                    chk(mult_factor == 3'(4 - wc), "R7 factor", mult_factor, 4 - wc);
                    // R4 PLL to main
                    req(1, 0);
                    run_switch();
                    chk(bc == 1, "R4 handoff length", bc, 1);
                    chk_src("R4 main", 0);
                end else begin
                    // R6 main to PLL lock wait
                    req(1, 1);
                    run_switch();
                    chk(tk == (1 << ELK), "R6 lock ticks", tk, 1 << ELK);
                    chk(first_src == 2'd0, "R6 main during lock", first_src, 0);
                    chk_src("R6 pll", 1);
                    chk(mult_factor == 3'(4 - wc), "R7 factor", mult_factor, 4 - wc);
                end
            end
        end

        // R7 relock sweep in PLL mode
        tick_mode = 0;
        req(1, 1);
        if (src_sel != 2'd1) run_switch();
        for (int k = 0; k < 4; k++) begin
            logic [1:0] nc;
            nc = 2'(mult_factor - 3'd1) + 2'd1 + 2'(k % 2);
            mult_code = nc;
            run_switch();
            chk(first_src == 2'd0, "R7 main during relock", first_src, 0);
            chk(tk == (1 << ELK), "R7 relock ticks", tk, 1 << ELK);
            chk_src("R7 back on pll", 1);
            chk(mult_factor == 3'(nc) + 3'd1, "R7 new factor", mult_factor, nc + 1);
        end

        // R7 code change outside PLL mode has no effect
        req(1, 0);
        run_switch();
        begin
            logic [2:0] f0;
            f0 = mult_factor;
            mult_code = 2'(f0);
            repeat (4) cyc();
            chk(b_seen == 1'b0, "R7 no switch in main", b_seen, 0);
            chk(mult_factor == f0, "R7 factor kept in main", mult_factor, f0);
        end

        // R2 sub wins over PLL request
        req(1, 1);
        run_switch();
        req(0, 1);
        run_switch();
        chk_src("R2 sub beats pll", 2);

        // R9 request held during a long wait, accepted right after
        stab_code = 2'd3;
        req(1, 1);
        tk = 0; bc = 0;
        cyc();
        repeat (3) cyc();
        req(0, 0);
        stab_code = 2'd0;
        for (int g = 0; g < 200 && b_seen; g++) cyc();
        chk(tk == stab_len(3), "R9 latched wait", tk, stab_len(3));
        chk_src("R9 first target kept", 1);
        cyc();
        chk(b_seen == 1'b1, "R9 held request accepted", b_seen, 1);
        cyc();
        chk_src("R9 held request done", 2);

        // R10 sleep handshake
        sleep_req = 1'b1;
        #1;
        chk(sleep_ack == 1'b1, "R10 idle ack", sleep_ack, 1);
        req(1, 0);
        #1;
        chk(sleep_ack == 1'b0, "R10 blocked on accept", sleep_ack, 0);
        cyc();
        #1;
        chk(sleep_ack == 1'b0, "R10 blocked while busy", sleep_ack, 0);
        for (int g = 0; g < 200 && b_seen; g++) cyc();
        #1;
        chk(sleep_ack == 1'b1, "R10 ack after switch", sleep_ack, 1);
        sleep_req = 1'b0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule